// File: doc/BRIEF.md
# Four-Lane Reed-Solomon Syndrome Engine

This block evaluates four Reed-Solomon syndromes over GF(2^8) in a single pass over a received codeword. Each of its four lanes runs Horner's rule against its own constant root. Every cycle the lane multiplies its running value by the root and adds the next symbol with a bitwise XOR. The symbols come from a local memory with a one-cycle read latency. The block drives the address and consumes the data that returns on the following cycle.

A user writes the codeword into memory with its highest-order symbol at address 0. The user places the four roots in a 32-bit word and pulses `start` with the symbol count N. After N accumulation cycles the four syndromes appear as two 16-bit words, and `done` pulses for one cycle. To get more than four syndromes, run the block again with a new set of roots.

Top module: `rs_syndrome4`

## Requirements
- R1: After reset, `busy`, `done`, `mem_addr`, `syn_lo` and `syn_hi` are all zero.
- R2: Once a job is accepted, `mem_addr` steps through 0, 1, ..., N-1, one address per cycle. Address k holds symbol R_{N-1-k}, and its data is read from `mem_rdata` one cycle later.
- R3: For each lane, the result equals the Horner evaluation S = (...((R_{N-1}·a + R_{N-2})·a + ...)·a + R_0). Products are taken in GF(2^8) modulo x^8+x^4+x^3+x^2+1 (0x11D), and sums are XOR. With root 0x01 the result is the XOR of all symbols. With root 0x00 the result is R_0.
- R4: The roots are captured from `roots` when the job is accepted. Lane 0 uses bits [31:24], lane 1 bits [23:16], lane 2 bits [15:8] and lane 3 bits [7:0].
- R5: The first symbol seeds each lane directly, without being multiplied. A job with N=1 therefore returns that symbol in all four lanes, whatever the roots are.
- R6: `syn_lo` = {S0, S1} and `syn_hi` = {S2, S3}, with the lower-numbered lane in the upper byte.
- R7: `done` is a one-cycle pulse. It is seen N+2 rising edges after the edge that accepts `start`, counting the accepting edge as the first. `busy` is high from acceptance until the edge that raises `done`. The result words change only at that edge.
- R8: While `busy` is high, `start` is ignored, together with the values on `sym_count` and `roots`. A `start` in the cycle where `done` is high is accepted.
- R9: A `start` with `sym_count` = 0 is ignored. The block stays idle and raises no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new job (sampled when idle) |
| sym_count | input | LEN_W | Codeword length N |
| roots | input | 4*SYM_W | Four lane roots, lane 0 in the top byte |
| mem_addr | output | LEN_W | Symbol memory read address |
| mem_rdata | input | SYM_W | Symbol memory data, one cycle after address |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse: results valid |
| syn_lo | output | 2*SYM_W | {S0, S1} |
| syn_hi | output | 2*SYM_W | {S2, S3} |

## Verification
The hardest situation to reach is a request that arrives while a job is running and carries a different length and different roots. If such a request leaked through, the address sequence or the captured roots would be corrupted partway through. The stimulus raises `start` with altered `sym_count` and `roots` a few cycles into a long job. It then checks that the latency and all four syndromes still match the original job. A second directed case raises `start` on the exact cycle `done` is high, where the request must be accepted, and runs the new job to completion. The stimulus also includes a length of one, to reach the direct seeding path, and a length of zero.

// File: rtl/rs_syndrome4.sv
`timescale 1ns/1ps
module rs_syndrome4 #(
  parameter int          SYM_W = 8,
  parameter int          LEN_W = 8,
  parameter logic [8:0]  POLY  = 9'h11D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   sym_count,
  input  logic [4*SYM_W-1:0] roots,
  output logic [LEN_W-1:0]   mem_addr,
  input  logic [SYM_W-1:0]   mem_rdata,
  output logic               busy,
  output logic               done,
  output logic [2*SYM_W-1:0] syn_lo,
  output logic [2*SYM_W-1:0] syn_hi
);
  localparam int LANES = 4;

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ POLY[SYM_W-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  logic               busy_q, fetch_q, dv_q, dfirst_q, dlast_q, done_q;
  logic [LEN_W-1:0]   addr_q, n_q;
  logic [4*SYM_W-1:0] roots_q;
  logic [2*SYM_W-1:0] lo_q, hi_q;
  logic [SYM_W-1:0]   lane_nxt [LANES];

  wire accept   = start && !busy_q && (sym_count != '0);
  wire at_last  = (addr_q == n_q - LEN_W'(1));
  wire finish   = dv_q && dlast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; fetch_q <= 1'b0; addr_q <= '0; n_q <= '0; roots_q <= '0;
      dv_q <= 1'b0; dfirst_q <= 1'b0; dlast_q <= 1'b0;
    end else begin
      dv_q     <= fetch_q;
      dfirst_q <= fetch_q && (addr_q == '0);
      dlast_q  <= fetch_q && at_last;
      if (accept) begin
        busy_q  <= 1'b1;
        fetch_q <= 1'b1;
        addr_q  <= '0;
        n_q     <= sym_count;
        roots_q <= roots;
      end else begin
        if (fetch_q) begin
          if (at_last) fetch_q <= 1'b0;
          else         addr_q  <= addr_q + LEN_W'(1);
        end
        if (finish) busy_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SYM_W-1:0] acc_r;
    wire  [SYM_W-1:0] root_w = roots_q[(LANES-1-g)*SYM_W +: SYM_W];
    assign lane_nxt[g] = dfirst_q ? mem_rdata : (gf_mul(acc_r, root_w) ^ mem_rdata);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_r <= '0;
      else if (dv_q) acc_r <= lane_nxt[g];
    end

    assert_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dv_q && dfirst_q) |=> (acc_r == $past(mem_rdata)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; lo_q <= '0; hi_q <= '0;
    end else begin
      done_q <= finish;
      if (finish) begin
        lo_q <= {lane_nxt[0], lane_nxt[1]};
        hi_q <= {lane_nxt[2], lane_nxt[3]};
      end
    end
  end

  assign mem_addr = addr_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign syn_lo   = lo_q;
  assign syn_hi   = hi_q;

  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |-> (addr_q < n_q));
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q && !at_last && !accept) |=> (addr_q == $past(addr_q) + LEN_W'(1)));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(syn_lo) && $stable(syn_hi)));
  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(n_q) && $stable(roots_q)));
  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && sym_count == '0) |=> !busy);
endmodule

// File: tb/rs_syndrome4_tb.sv
`timescale 1ns/1ps
module rs_syndrome4_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  sym_count = '0;
  logic [31:0] roots = '0;
  logic [7:0]  mem_addr, mem_rdata;
  logic        busy, done;
  logic [15:0] syn_lo, syn_hi;
  logic [7:0]  mem [256];
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rs_syndrome4 u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sym_count(sym_count), .roots(roots),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .syn_lo(syn_lo), .syn_hi(syn_hi));

  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  // {n, roots, seed, step, poke}
  localparam int NV = 6;
  localparam logic [56:0] VEC [NV] = '{
    {8'd1,   32'h021D80FF, 8'hA5, 8'd3,  1'b0},
    {8'd4,   32'h01010101, 8'h3C, 8'd17, 1'b0},
    {8'd4,   32'h00000000, 8'h71, 8'd29, 1'b0},
    {8'd16,  32'h02040810, 8'h00, 8'd1,  1'b1},
    {8'd255, 32'h02040810, 8'h5A, 8'd77, 1'b0},
    {8'd50,  32'h8E4C1D03, 8'hC3, 8'd11, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gfm(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'(9'h11D) << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] horner(input int n, input logic [7:0] r);
    logic [7:0] s = '0;
    for (int k = 0; k < n; k++) s = gfm(s, r) ^ mem[k];
    return s;
  endfunction

  task automatic fill(input logic [7:0] sd, input logic [7:0] st);
    for (int a = 0; a < 256; a++) mem[a] = 8'(sd + 8'(a) * st) ^ 8'(a >> 2);
  endtask

  task automatic launch(input int n, input logic [31:0] r);
    sym_count = 8'(n); roots = r; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int poke_at, input int n, output int k);
    k = 1;
    while (!done && k < 600) begin
      @(posedge clk); k++; @(negedge clk);
      if (poke_at != 0 && k == poke_at) begin
        check(busy, "R7 busy mid-job", 32'(busy), 1);
        start = 1'b1; sym_count = 8'(n + 5); roots = ~roots;
      end
      if (poke_at != 0 && k == poke_at + 1) start = 1'b0;
    end
  endtask

  function automatic logic [31:0] expect_all(input int n, input logic [31:0] r);
    return {horner(n, r[31:24]), horner(n, r[23:16]), horner(n, r[15:8]), horner(n, r[7:0])};
  endfunction

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    logic [31:0] e, e2;
    logic [15:0] lo_h, hi_h;
    fill(8'h11, 8'd5);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done, "R1 reset flags", {busy, done}, 0);
    check(syn_lo == 0 && syn_hi == 0, "R1 reset results", {syn_lo, syn_hi}, 0);
    check(mem_addr == 0, "R1 reset addr", 32'(mem_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int n = int'(VEC[v][56:49]);
      logic [31:0] r = VEC[v][48:17];
      fill(VEC[v][16:9], VEC[v][8:1]);
      e = expect_all(n, r);
      launch(n, r);
      check(busy, "R7 busy after accept", 32'(busy), 1);
      check(mem_addr == 0, "R2 first address", 32'(mem_addr), 0);
      wait_done(VEC[v][0] ? 4 : 0, n, k);
      check(done && k == n + 2, "R7 latency", 32'(k), 32'(n + 2));
      check({syn_lo, syn_hi} == e, "R3 R4 R6 syndromes", {syn_lo, syn_hi}, e);
      if (n == 1) check({syn_lo, syn_hi} == {4{mem[0]}}, "R5 seed", {syn_lo, syn_hi}, {4{mem[0]}});
      if (r == 32'h01010101) begin
        logic [7:0] x = '0;
        for (int q = 0; q < n; q++) x = x ^ mem[q];
        check(syn_lo[15:8] == x, "R3 root one xor", 32'(syn_lo[15:8]), 32'(x));
      end
      if (r == 0) check(syn_hi[7:0] == mem[n-1], "R3 root zero", 32'(syn_hi[7:0]), 32'(mem[n-1]));
      lo_h = syn_lo; hi_h = syn_hi;
      @(posedge clk); @(negedge clk);
      check(!done, "R7 done one cycle", 32'(done), 0);
      check(!busy, "R8 no restart from ignored start", 32'(busy), 0);
      check(syn_lo == lo_h && syn_hi == hi_h, "R7 results held", {syn_lo, syn_hi}, {lo_h, hi_h});
    end

    // R8 start in done cycle is accepted
    fill(8'h2B, 8'd9);
    e  = expect_all(6, 32'h03050709);
    e2 = expect_all(3, 32'h1D1D0201);
    launch(6, 32'h03050709);
    wait_done(0, 6, k);
    check({syn_lo, syn_hi} == e, "R8 first of pair", {syn_lo, syn_hi}, e);
    launch(3, 32'h1D1D0201);
    check(busy, "R8 accepted on done cycle", 32'(busy), 1);
    wait_done(0, 3, k);
    check(k == 5, "R8 second latency", 32'(k), 5);
    check({syn_lo, syn_hi} == e2, "R8 second of pair", {syn_lo, syn_hi}, e2);
    @(posedge clk); @(negedge clk);

    // R9 zero length ignored
    lo_h = syn_lo; hi_h = syn_hi;
    launch(0, 32'hFFFFFFFF);
    check(!busy, "R9 zero length idle", 32'(busy), 0);
    begin
      bit seen = 0;
      repeat (4) begin @(posedge clk); @(negedge clk); if (done) seen = 1; end
      check(!seen, "R9 no done", 32'(seen), 0);
    end
    check(syn_lo == lo_h && syn_hi == hi_h, "R9 results untouched", {syn_lo, syn_hi}, {lo_h, hi_h});

    // R1 reset in the middle of a job
    launch(40, 32'h02030405);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !done && mem_addr == 0, "R1 mid-job reset", {busy, done, mem_addr}, 0);
    check(syn_lo == 0 && syn_hi == 0, "R1 mid-job reset results", {syn_lo, syn_hi}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule